// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Pool

This block is a programmable two-level logic array. A vector of thirty-six inputs is expanded into literal columns, with each input offered both as itself and as its inverse. An AND plane then builds a pool of eighty-six product terms from those columns. A steering matrix picks, for each of sixteen outputs, which product terms from the pool are ORed into that output's sum. A product term is not owned by any one output. Any number of outputs may use the same term, and each output may take from zero to sixteen terms.

The contents of both planes are written through a one-bit serial load port. The port has an enable and a data line, and it samples on the rising clock edge. A load runs over every AND-plane bit first and every steering bit after that. The path from the input vector to the sums has no register in it.

A steering row that selects more than the allowed number of terms is clipped to its lowest-indexed terms. When that happens, a sticky overflow flag is raised.

Top module: `sop_term_pool`

## Requirements
- R1: Input i drives literal column 2*i as itself and literal column 2*i+1 as its inverse.
- R2: A product term is the AND of the literal columns whose AND-plane bit is 1. A term with no bit set evaluates to 1.
- R3: Output o is the OR of the product terms whose steering bit for o is 1. An output with no steered term is 0.
- R4: A single product term steered to several outputs drives all of them at the same time.
- R5: At most 16 terms are kept per output. If a load selects more, only the 16 with the lowest term indices take effect.
- R6: `steer_overflow` becomes 1 when a load asks for more than 16 terms on any output. Only reset clears it; a later clean load does not.
- R7: Each rising clock edge with `cfg_en` high stores one bit of `cfg_data`. The bits are stored in this order:
  - first, AND-plane bit (term t, column c) at stream position t*72+c;
  - then, steering bit (output o, term t) at position 6192+o*86+t.
- R8: A cycle with `cfg_en` low sends the next load back to stream position 0. Bits sent after position 7567 of a load are ignored.
- R9: Synchronous active-high `rst` clears both planes and the flag. After reset every output reads 0 for any input.
- R10: The sums follow `in_vec` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load-port clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Serial load enable |
| cfg_data | input | 1 | Serial load data bit |
| in_vec | input | 36 | Array inputs |
| sum_out | output | 16 | Per-output OR sums |
| steer_overflow | output | 1 | Sticky over-limit steering flag |

## Verification
The first configuration mixes several kinds of term:
- a two-literal term that uses one true column and one inverted column;
- a single-literal term shared by two outputs;
- an empty term, which is constant 1;
- a three-literal term at the top input indices;
- an output that nothing drives.

The input patterns walk through all-zero, all-one and selected mixes. Together they separate a swapped polarity, a lost share, a wrong empty-term value and an off-by-one column.

A second configuration steers seventeen single-input terms to one output and exactly sixteen to another. Setting only the seventeenth input tells clipping apart from no clipping. It also shows that the flag comes from the over-limit row and not from the full one.

Two further loads check how the load port behaves. A short reload after a gap must rewrite term 0. Extra bits sent past the end of a load must leave the array unchanged.

// File: rtl/sop_pool_pkg.sv
package sop_pool_pkg;

    localparam int unsigned DEF_INPUTS   = 36;
    localparam int unsigned DEF_TERMS    = 86;
    localparam int unsigned DEF_OUTPUTS  = 16;
    localparam int unsigned DEF_PER_OUT  = 16;

    typedef enum logic [1:0] {
        LOAD_AND   = 2'd0,
        LOAD_STEER = 2'd1,
        LOAD_DONE  = 2'd2
    } load_phase_e;

    // Column that carries input idx in the chosen polarity.
    function automatic int unsigned lit_col(input int unsigned idx, input bit inverted);
        return 2 * idx + (inverted ? 1 : 0);
    endfunction

    function automatic int unsigned stream_len(input int unsigned n_in,
                                               input int unsigned n_term,
                                               input int unsigned n_out);
        return 2 * n_in * n_term + n_term * n_out;
    endfunction

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader
    import sop_pool_pkg::*;
#(
    parameter int unsigned N_IN    = DEF_INPUTS,
    parameter int unsigned N_TERM  = DEF_TERMS,
    parameter int unsigned N_OUT   = DEF_OUTPUTS,
    parameter int unsigned PER_OUT = DEF_PER_OUT
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_en,
    input  logic                               cfg_data,
    output logic [N_TERM-1:0][2*N_IN-1:0]      and_mask,
    output logic [N_OUT-1:0][N_TERM-1:0]       steer_mask,
    output logic                               overflow
);
    localparam int unsigned N_LIT = 2 * N_IN;
    localparam int unsigned LW    = (N_LIT  > 1) ? $clog2(N_LIT)  : 1;
    localparam int unsigned TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1;
    localparam int unsigned OW    = (N_OUT  > 1) ? $clog2(N_OUT)  : 1;
    localparam int unsigned CW    = $clog2(PER_OUT + 1);

    localparam logic [LW-1:0] LIT_LAST  = LW'(N_LIT - 1);
    localparam logic [TW-1:0] TERM_LAST = TW'(N_TERM - 1);
    localparam logic [OW-1:0] OUT_LAST  = OW'(N_OUT - 1);
    localparam logic [CW-1:0] CNT_CAP   = CW'(PER_OUT);

    load_phase_e      phase_q;
    logic [TW-1:0]    a_row_q;
    logic [LW-1:0]    a_col_q;
    logic [OW-1:0]    s_row_q;
    logic [TW-1:0]    s_col_q;
    logic [CW-1:0]    kept_q;
    logic [N_TERM-1:0][N_LIT-1:0] and_q;
    logic [N_OUT-1:0][N_TERM-1:0] steer_q;
    logic             err_q;

    logic             room;
    logic             keep_bit;

    assign room     = (kept_q < CNT_CAP);
    assign keep_bit = cfg_data && room;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= LOAD_AND;
            a_row_q <= '0;
            a_col_q <= '0;
            s_row_q <= '0;
            s_col_q <= '0;
            kept_q  <= '0;
            and_q   <= '0;
            steer_q <= '0;
            err_q   <= 1'b0;
        end else if (!cfg_en) begin
            phase_q <= LOAD_AND;
            a_row_q <= '0;
            a_col_q <= '0;
            s_row_q <= '0;
            s_col_q <= '0;
            kept_q  <= '0;
        end else begin
            unique case (phase_q)
                LOAD_AND: begin
                    and_q[a_row_q][a_col_q] <= cfg_data;
                    if (a_col_q == LIT_LAST) begin
                        a_col_q <= '0;
                        if (a_row_q == TERM_LAST) begin
                            a_row_q <= '0;
                            phase_q <= LOAD_STEER;
                            kept_q  <= '0;
                        end else begin
                            a_row_q <= a_row_q + 1'b1;
                        end
                    end else begin
                        a_col_q <= a_col_q + 1'b1;
                    end
                end
                LOAD_STEER: begin
                    // A row is rebuilt from empty so the kept count bounds it.
                    if (s_col_q == '0) begin
                        steer_q[s_row_q] <= '0;
                    end
                    steer_q[s_row_q][s_col_q] <= keep_bit;
                    if (cfg_data && !room) begin
                        err_q <= 1'b1;
                    end
                    if (s_col_q == TERM_LAST) begin
                        s_col_q <= '0;
                        kept_q  <= '0;
                        if (s_row_q == OUT_LAST) begin
                            s_row_q <= '0;
                            phase_q <= LOAD_DONE;
                        end else begin
                            s_row_q <= s_row_q + 1'b1;
                        end
                    end else begin
                        s_col_q <= s_col_q + 1'b1;
                        if (keep_bit) begin
                            kept_q <= kept_q + 1'b1;
                        end
                    end
                end
                default: begin
                    phase_q <= LOAD_DONE;
                end
            endcase
        end
    end

    assign and_mask   = and_q;
    assign steer_mask = steer_q;
    assign overflow   = err_q;

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!err_q && steer_q == '0 && and_q == '0));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (phase_q == LOAD_AND));

    p_done_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LOAD_DONE) |=> ($stable(and_q) && $stable(steer_q)));

    p_err_needs_steer_r6: assert property (@(posedge clk) disable iff (rst)
        (!err_q && phase_q != LOAD_STEER) |=> !err_q);

    for (genvar o = 0; o < N_OUT; o++) begin : g_cap_chk
        p_row_cap_r5: assert property (@(posedge clk) disable iff (rst)
            $countones(steer_q[o]) <= PER_OUT);
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pool_pkg::*;
#(
    parameter int unsigned N_IN   = DEF_INPUTS,
    parameter int unsigned N_TERM = DEF_TERMS
) (
    input  logic [N_IN-1:0]                 in_vec,
    input  logic [N_TERM-1:0][2*N_IN-1:0]   and_mask,
    output logic [N_TERM-1:0]               terms
);
    localparam int unsigned N_LIT = 2 * N_IN;

    logic [N_LIT-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[lit_col(i, 1'b0)] = in_vec[i];
        assign lits[lit_col(i, 1'b1)] = ~in_vec[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // Unselected columns are forced high, so an empty row yields 1.
        assign terms[t] = &(lits | ~and_mask[t]);

        always_comb begin
            if (and_mask[t] == '0) begin
                p_empty_term_one_r2: assert (terms[t] == 1'b1);
            end
        end
    end

endmodule

// File: rtl/sop_or_steer.sv
module sop_or_steer
    import sop_pool_pkg::*;
#(
    parameter int unsigned N_TERM = DEF_TERMS,
    parameter int unsigned N_OUT  = DEF_OUTPUTS
) (
    input  logic [N_TERM-1:0]              terms,
    input  logic [N_OUT-1:0][N_TERM-1:0]   steer_mask,
    output logic [N_OUT-1:0]               sums
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sums[o] = |(terms & steer_mask[o]);

        always_comb begin
            if (steer_mask[o] == '0) begin
                p_unsteered_zero_r3: assert (sums[o] == 1'b0);
            end
        end
    end

endmodule

// File: rtl/sop_term_pool.sv
module sop_term_pool
    import sop_pool_pkg::*;
#(
    parameter int unsigned N_IN    = DEF_INPUTS,
    parameter int unsigned N_TERM  = DEF_TERMS,
    parameter int unsigned N_OUT   = DEF_OUTPUTS,
    parameter int unsigned PER_OUT = DEF_PER_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_data,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  sum_out,
    output logic              steer_overflow
);
    logic [N_TERM-1:0][2*N_IN-1:0] and_mask;
    logic [N_OUT-1:0][N_TERM-1:0]  steer_mask;
    logic [N_TERM-1:0]             terms;

    sop_cfg_loader #(
        .N_IN    (N_IN),
        .N_TERM  (N_TERM),
        .N_OUT   (N_OUT),
        .PER_OUT (PER_OUT)
    ) loader_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_data   (cfg_data),
        .and_mask   (and_mask),
        .steer_mask (steer_mask),
        .overflow   (steer_overflow)
    );

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) and_i (
        .in_vec   (in_vec),
        .and_mask (and_mask),
        .terms    (terms)
    );

    sop_or_steer #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) or_i (
        .terms      (terms),
        .steer_mask (steer_mask),
        .sums       (sum_out)
    );

endmodule

// File: tb/sop_term_pool_tb.sv
module sop_term_pool_tb_top;

    localparam int NI = 36;
    localparam int NT = 86;
    localparam int NO = 16;
    localparam int NL = 2 * NI;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_en;
    logic          cfg_data;
    logic [NI-1:0] in_vec;
    logic [NO-1:0] sum_out;
    logic          steer_overflow;

    int checks = 0;
    int bad    = 0;
    int cycles = 0;

    logic [NT-1:0][NL-1:0] bm;
    logic [NO-1:0][NT-1:0] bs;

    localparam logic [35:0] VIN [7] = '{
        36'h0, 36'h1, 36'h3, 36'h4,
        36'hC00000003, 36'hE00000000, 36'hFFFFFFFFF
    };
    localparam logic [15:0] VEXP [7] = '{
        16'h0024, 16'h0025, 16'h0004, 16'h0027,
        16'h0014, 16'h0024, 16'h0007
    };

    sop_term_pool dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_en         (cfg_en),
        .cfg_data       (cfg_data),
        .in_vec         (in_vec),
        .sum_out        (sum_out),
        .steer_overflow (steer_overflow)
    );

    always #5 clk = ~clk;

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad    = bad + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Streams bm then bs with cfg_en high; the last bit is stored at the next edge.
    task automatic load_cfg(input int extra_ones);
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < NL; c++) begin
                @(negedge clk); cfg_en = 1'b1; cfg_data = bm[t][c];
            end
        end
        for (int o = 0; o < NO; o++) begin
            for (int t = 0; t < NT; t++) begin
                @(negedge clk); cfg_en = 1'b1; cfg_data = bs[o][t];
            end
        end
        for (int k = 0; k < extra_ones; k++) begin
            @(negedge clk); cfg_en = 1'b1; cfg_data = 1'b1;
        end
        @(negedge clk); cfg_en = 1'b0; cfg_data = 1'b0;
        @(negedge clk);
    endtask

    task automatic apply(input logic [NI-1:0] v);
        @(negedge clk); in_vec = v; #1;
    endtask

    task automatic set_cfg_a();
        bm = '0; bs = '0;
        bm[0][0] = 1'b1; bm[0][3] = 1'b1;                    // in0 & ~in1
        bm[1][4] = 1'b1;                                     // in2
        bm[3][70] = 1'b1; bm[3][68] = 1'b1; bm[3][67] = 1'b1; // in35 & in34 & ~in33
        bm[4][1] = 1'b1;                                     // ~in0
        bs[0][0] = 1'b1; bs[0][1] = 1'b1;
        bs[1][1] = 1'b1;
        bs[2][2] = 1'b1;
        bs[4][3] = 1'b1;
        bs[5][4] = 1'b1; bs[5][0] = 1'b1;
    endtask

    task automatic set_cfg_b();
        bm = '0; bs = '0;
        for (int k = 0; k < 17; k++) begin
            bm[10+k][2*k] = 1'b1;
            bs[7][10+k]   = 1'b1;
        end
        for (int k = 0; k < 16; k++) begin
            bm[30+k][2*(20+k)] = 1'b1;
            bs[8][30+k]        = 1'b1;
        end
    endtask

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_data = 1'b0; in_vec = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        apply(36'h5A5A5A5A5);
        chk("R9 reset sums", 32'(sum_out), 32'h0);
        chk("R9 reset flag", 32'(steer_overflow), 32'h0);

        // R1 R2 R3 R4 R7 R10: vector table under configuration A
        set_cfg_a();
        load_cfg(0);
        chk("R6 flag clean load", 32'(steer_overflow), 32'h0);
        for (int i = 0; i < 7; i++) begin
            apply(VIN[i]);
            chk($sformatf("R1 R2 R3 R4 R10 vector %0d", i), 32'(sum_out), 32'(VEXP[i]));
        end

        // R4: shared term drives out0 and out1 together
        apply(36'h4);
        chk("R4 shared term", 32'(sum_out[1:0]), 32'h3);

        // R8: restart after gap; 72 zeros empty term 0, which then reads 1
        for (int c = 0; c < NL; c++) begin
            @(negedge clk); cfg_en = 1'b1; cfg_data = 1'b0;
        end
        @(negedge clk); cfg_en = 1'b0;
        apply(36'h3);
        chk("R8 reload restarts at position 0", 32'(sum_out), 32'h0025);

        // R8: bits after the end of a load are ignored
        set_cfg_a();
        load_cfg(200);
        apply(36'h0);
        chk("R8 trailing bits ignored", 32'(sum_out), 32'h0024);
        apply(36'hFFFFFFFFF);
        chk("R8 trailing bits ignored all-ones", 32'(sum_out), 32'h0007);

        // R5 R6: configuration B, 17 terms on out7, 16 on out8
        set_cfg_b();
        load_cfg(0);
        chk("R6 flag set on over-limit", 32'(steer_overflow), 32'h1);
        apply(36'h10000);
        chk("R5 seventeenth term dropped", 32'(sum_out), 32'h0);
        apply(36'h08000);
        chk("R5 sixteenth term kept", 32'(sum_out), 32'h0080);
        apply(36'h1);
        chk("R5 lowest term kept", 32'(sum_out), 32'h0080);
        apply(36'h800000000);
        chk("R5 full row of 16 used", 32'(sum_out), 32'h0100);

        // R6: a clean reload does not clear the flag
        set_cfg_a();
        load_cfg(0);
        chk("R6 flag sticky across clean load", 32'(steer_overflow), 32'h1);
        apply(36'h1);
        chk("R3 config A restored", 32'(sum_out), 32'h0025);

        // R9: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply(36'hFFFFFFFFF);
        chk("R9 sums after reset", 32'(sum_out), 32'h0);
        chk("R9 flag after reset", 32'(steer_overflow), 32'h0);

        summary_and_end();
    end

endmodule